// File: doc/BRIEF.md
# Dual-Target Interrupt Cause/Mask Controller

This block gathers 32 level-type interrupt sources and presents them to two processor targets, target A and target B. Each target keeps a private cause register, which records sources seen high, and a private mask register, which chooses the sources that may interrupt it. A target's interrupt line is raised while at least one source is both recorded in its cause register and enabled in its mask.

Software reaches the six 32-bit registers through a simple word-addressed port with separate read and write strobes. A handler acknowledges a request by writing ones to the cause bits it has serviced. It can find the next source to service by reading a per-target register that reports the lowest-numbered active source. To shut a target off completely, software writes zero to its mask and all ones to its cause register.

Top module: `irq_dual_ctl`

## Requirements
- R1: After reset both cause registers and both mask registers read 0 and both interrupt outputs are low.
- R2: A source input that is high at a rising clock edge sets its bit in the cause register of both targets at that edge.
- R3: A write to a cause register (target A at byte offset 0x00, target B at 0x08) clears each bit written as 1 and leaves each bit written as 0 unchanged. The other target's cause register is not affected.
- R4: When a source is high in the same cycle that its cause bit is written with 1, the bit stays set, because the set takes priority over the clear.
- R5: Mask registers (target A at 0x04, target B at 0x0C) read back the last value written. A 1 bit enables that source. A write to one target's mask leaves the other target's mask unchanged.
- R6: irq_o[0] (target A) and irq_o[1] (target B) are high exactly when that target's cause AND mask is nonzero. The output follows a register write or a source edge in the same clock edge.
- R7: Read-only registers at 0x10 (target A) and 0x14 (target B) return, in bits 4:0, the index of the lowest-numbered source whose cause and mask bits are both 1. When no such source exists they return 0x80000000, which is bit 31 set and all other bits zero.
- R8: A read strobed at a clock edge presents its data on reg_rdata_o after that edge, and the data is held until the next read.
- R9: Reads of offsets not listed above, and of offsets not aligned to a word, return 0. Writes to those offsets, and to 0x10 or 0x14, change no register.
- R10: With the sources low, writing 0 to a target's mask and 0xFFFFFFFF to its cause register leaves both registers at 0 and drops that target's output. The other target is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt sources, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_rd_i |
| irq_o | output | 2 | Interrupt outputs, bit 0 target A, bit 1 target B |

## Verification
The embedded properties assume that src_i is already synchronous to clk and that reg_rd_i and reg_wr_i are never both high in the same cycle. Under these assumptions, a bit cleared by a write stays clear unless its source is high. The bench drives every input on the falling edge and issues one register access per cycle. It raises sources either as one-cycle pulses or as held levels, and it holds a source high across its own acknowledge only when it is deliberately testing that the set takes priority over the clear.

// File: rtl/irq_dual_pkg.sv
package irq_dual_pkg;
   // Register slots per target: cause at 2t, mask at 2t+1, lowest-active at 2*NUM_TGT+t
   localparam int unsigned SLOTS_PER_TGT = 3;

   function automatic int unsigned cause_slot(int unsigned t);
      return 2 * t;
   endfunction

   function automatic int unsigned mask_slot(int unsigned t);
      return 2 * t + 1;
   endfunction

   function automatic int unsigned low_slot(int unsigned t, int unsigned ntgt);
      return 2 * ntgt + t;
   endfunction
endpackage

// File: rtl/irq_low_enc.sv
module irq_low_enc #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic [N_SRC-1:0]  act_i,
   output logic [DATA_W-1:0] word_o
);
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (IDX_W >= DATA_W) begin : g_bad_width
      $error("irq_low_enc: index does not fit below the empty flag");
   end

   logic [IDX_W-1:0] idx;
   logic             empty;

   always_comb begin
      idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (act_i[i]) idx = IDX_W'(i);
      end
      empty = (act_i == '0);
   end

   always_comb begin
      word_o             = '0;
      word_o[DATA_W-1]   = empty;
      if (!empty) word_o[IDX_W-1:0] = idx;
   end
endmodule

// File: rtl/irq_tgt_bank.sv
module irq_tgt_bank #(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic             cause_we_i,
   input  logic             mask_we_i,
   input  logic [N_SRC-1:0] wdata_i,
   output logic [N_SRC-1:0] cause_o,
   output logic [N_SRC-1:0] mask_o,
   output logic [N_SRC-1:0] act_o,
   output logic             irq_o
);
   logic [N_SRC-1:0] cause_q, mask_q, clr;

   assign clr = cause_we_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else begin
         cause_q <= (cause_q & ~clr) | src_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mask_we_i) begin
         mask_q <= wdata_i;
      end
   end

   assign cause_o = cause_q;
   assign mask_o  = mask_q;
   assign act_o   = cause_q & mask_q;
   assign irq_o   = |act_o;

   // R2: a high source is recorded at the edge it is sampled
   a_r2_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

   // R3: bits written as one and not re-raised are cleared
   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cause_we_i |=> ((cause_q & $past(wdata_i) & ~$past(src_i)) == '0));

   // R3: without a cause write no recorded bit is lost
   a_r3_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_we_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   // R4: set beats clear
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_we_i && ((wdata_i & src_i) != '0)) |=>
         ((cause_q & $past(wdata_i & src_i)) == $past(wdata_i & src_i)));

   // R5: mask only moves on its own write
   a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_dual_ctl.sv
module irq_dual_ctl #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_TGT  = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic [N_TGT-1:0]  irq_o
);
   import irq_dual_pkg::*;

   localparam int unsigned N_SLOT = SLOTS_PER_TGT * N_TGT;
   localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

   if (N_SRC > DATA_W) begin : g_bad_src
      $error("irq_dual_ctl: more sources than data bits");
   end
   if (SLOT_W + 2 > ADDR_W) begin : g_bad_addr
      $error("irq_dual_ctl: address too narrow for register set");
   end
   if (N_TGT < 1) begin : g_bad_tgt
      $error("irq_dual_ctl: need at least one target");
   end

   logic [ADDR_W-3:0] slot;
   logic              listed;

   assign slot   = reg_addr_i[ADDR_W-1:2];
   assign listed = (reg_addr_i[1:0] == 2'b00) && (int'(slot) < N_SLOT);

   logic [N_SRC-1:0]  cause_v [N_TGT];
   logic [N_SRC-1:0]  mask_v  [N_TGT];
   logic [N_SRC-1:0]  act_v   [N_TGT];
   logic [DATA_W-1:0] low_v   [N_TGT];

   for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
      logic cause_we, mask_we;

      assign cause_we = reg_wr_i && listed && (int'(slot) == cause_slot(t));
      assign mask_we  = reg_wr_i && listed && (int'(slot) == mask_slot(t));

      irq_tgt_bank #(.N_SRC(N_SRC)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .src_i      (src_i),
         .cause_we_i (cause_we),
         .mask_we_i  (mask_we),
         .wdata_i    (reg_wdata_i[N_SRC-1:0]),
         .cause_o    (cause_v[t]),
         .mask_o     (mask_v[t]),
         .act_o      (act_v[t]),
         .irq_o      (irq_o[t])
      );

      irq_low_enc #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_low (
         .act_i  (act_v[t]),
         .word_o (low_v[t])
      );

      // R6: a fully masked target stays quiet
      a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_v[t] == '0) |-> !irq_o[t]);

      // R6: a raised output implies a recorded, enabled source
      a_r6_raise_cause: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[t] |-> ((cause_v[t] & mask_v[t]) != '0));

      // R7: empty flag in the lowest-active word matches the output
      a_r7_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
         low_v[t][DATA_W-1] == !irq_o[t]);
   end

   logic [DATA_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (listed) begin
         for (int t = 0; t < int'(N_TGT); t++) begin
            if (int'(slot) == cause_slot(t))      rd_word = DATA_W'(cause_v[t]);
            if (int'(slot) == mask_slot(t))       rd_word = DATA_W'(mask_v[t]);
            if (int'(slot) == low_slot(t, N_TGT)) rd_word = low_v[t];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata_o <= '0;
      end else if (reg_rd_i) begin
         reg_rdata_o <= rd_word;
      end
   end

   // R1: outputs are quiet on the first cycle out of reset
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_o == '0));

   // R9: unlisted offsets read as zero
   a_r9_unlisted_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && !listed) |=> (reg_rdata_o == '0));

   // R8: read data holds between reads
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/tb_irq_dual_ctl.sv
`timescale 1ns/1ps
module tb_irq_dual_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        reg_wr_i = 1'b0;
   logic        reg_rd_i = 1'b0;
   logic [4:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic [1:0]  irq_o;

   irq_dual_ctl dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src_i),
      .reg_wr_i    (reg_wr_i),
      .reg_rd_i    (reg_rd_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .irq_o       (irq_o)
   );

   always #4 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t exp_q[$];

   // bench model of the register state, built from the requirements
   logic [31:0] m_cause [2];
   logic [31:0] m_mask  [2];

   function automatic logic [31:0] lowest(logic [31:0] v);
      logic [31:0] r;
      r = 32'h8000_0000;
      for (int i = 31; i >= 0; i--) if (v[i]) r = i;
      return r;
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected item for a read issued the previous cycle
   logic rd_pend = 1'b0;
   always @(posedge clk) rd_pend <= reg_rd_i;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8: unexpected read data %h expected none", reg_rdata_o);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check(reg_rdata_o, it.exp, it.tag);
         end
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      if (a == 5'h00) m_cause[0] = (m_cause[0] & ~d) | src_i;
      if (a == 5'h08) m_cause[1] = (m_cause[1] & ~d) | src_i;
      if (a == 5'h04) m_mask[0] = d;
      if (a == 5'h0C) m_mask[1] = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_rd_i = 1'b1; reg_addr_i = a;
      it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      reg_rd_i = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk);
      src_i = v;
      m_cause[0] |= v; m_cause[1] |= v;
      @(negedge clk);
      src_i = '0;
   endtask

   task automatic chk_model(input string tag);
      rd(5'h00, m_cause[0], {tag, " causeA"});
      rd(5'h08, m_cause[1], {tag, " causeB"});
      rd(5'h10, lowest(m_cause[0] & m_mask[0]), {tag, " lowA"});
      rd(5'h14, lowest(m_cause[1] & m_mask[1]), {tag, " lowB"});
      check({30'b0, irq_o}, {30'b0, |(m_cause[1] & m_mask[1]), |(m_cause[0] & m_mask[0])},
            {tag, " irq"});
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R8: %0d reads unanswered expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_cause[0] = '0; m_cause[1] = '0; m_mask[0] = '0; m_mask[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check({30'b0, irq_o}, 32'h0, "R1 irq after reset");
      rd(5'h00, 32'h0, "R1 causeA");
      rd(5'h04, 32'h0, "R1 maskA");
      rd(5'h08, 32'h0, "R1 causeB");
      rd(5'h0C, 32'h0, "R1 maskB");

      // R2: a pulse sets the bit for both targets, masks keep outputs low
      pulse(32'h0000_0020);
      rd(5'h00, 32'h0000_0020, "R2 causeA set");
      rd(5'h08, 32'h0000_0020, "R2 causeB set");
      check({30'b0, irq_o}, 32'h0, "R6 masked irq low");

      // R5/R6: enable on A only
      wr(5'h04, 32'h0000_0020);
      check({30'b0, irq_o}, 32'h1, "R6 irqA only");
      rd(5'h04, 32'h0000_0020, "R5 maskA readback");
      rd(5'h0C, 32'h0, "R5 maskB untouched");
      rd(5'h10, 32'h5, "R7 lowA index 5");
      rd(5'h14, 32'h8000_0000, "R7 lowB empty");

      // R7: several sources, lowest enabled wins
      pulse(32'h0000_0208);
      wr(5'h04, 32'h0000_0220);
      wr(5'h0C, 32'h0000_0208);
      rd(5'h0C, 32'h0000_0208, "R5 maskB readback");
      rd(5'h04, 32'h0000_0220, "R5 maskA kept");
      chk_model("R7 multi");

      // R3: W1C on A only, zeros leave bits alone
      wr(5'h00, 32'h0000_0020);
      chk_model("R3 w1c A");
      rd(5'h08, 32'h0000_0228, "R3 causeB unaffected");
      wr(5'h00, 32'h0000_0000);
      rd(5'h00, 32'h0000_0208, "R3 zero write keeps");

      // R4: held level survives its own acknowledge
      @(negedge clk);
      src_i = 32'h0000_1000;
      m_cause[0] |= src_i; m_cause[1] |= src_i;
      wr(5'h00, 32'h0000_1000);
      rd(5'h00, 32'h0000_1208, "R4 set wins");
      src_i = '0;
      wr(5'h00, 32'h0000_1000);
      rd(5'h00, 32'h0000_0208, "R4 cleared after release");

      // R8: read latency, data appears after one edge and holds
      rd(5'h0C, 32'h0000_0208, "R8 one-cycle read");
      repeat (2) @(negedge clk);
      check(reg_rdata_o, 32'h0000_0208, "R8 data held");

      // R9: unlisted, unaligned and read-only offsets
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h05, 32'hFFFF_FFFF);
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h1C, 32'hFFFF_FFFF);
      rd(5'h18, 32'h0, "R9 unlisted 0x18 reads 0");
      rd(5'h1C, 32'h0, "R9 unlisted 0x1C reads 0");
      rd(5'h01, 32'h0, "R9 unaligned reads 0");
      rd(5'h04, 32'h0000_0220, "R9 maskA unchanged");
      rd(5'h0C, 32'h0000_0208, "R9 maskB unchanged");
      chk_model("R9 state kept");

      // R10: quiesce target B, A keeps running
      wr(5'h0C, 32'h0);
      wr(5'h08, 32'hFFFF_FFFF);
      rd(5'h08, 32'h0, "R10 causeB cleared");
      rd(5'h0C, 32'h0, "R10 maskB cleared");
      check({31'b0, irq_o[1]}, 32'h0, "R10 irqB low");
      check({31'b0, irq_o[0]}, 32'h1, "R10 irqA still high");
      chk_model("R10 final");

      done = 1'b1;
      finish_run();
   end
endmodule